// File: doc/BRIEF.md
# Host Bridge Control Register File

This block holds the word-wide control registers of a host bridge behind a plain 32-bit register bus. A bus master writes by presenting a byte address, write data and a write strobe for one clock. It reads by presenting an address: the read data is combinational from the current register contents. The register number is the byte address with its two low bits dropped. Only aligned word writes are accepted.

Most registers are ordinary storage. The interrupt enable mask cannot be written directly. A write to the enable-set register stores the word there and ORs its one bits into the mask. A write to the enable-clear register stores the word there and removes its one bits from the mask. The interrupt status register copies an external status vector on every clock, so the mask and the status register are both read-only to the bus.

Bit 2 of the general configuration register is watched by a two-state sequencer. In state RQ_IDLE it waits. A write that moves the bit from 0 to 1 takes the transition IDLE-to-FIRE. RQ_FIRE drives a one-clock system reset request. The sequencer then takes FIRE-to-IDLE, or stays in FIRE if another qualifying write arrives. With no qualifying write it stays in IDLE.

Top module: `hbr_ctrl_regs`

## Requirements
- R1: Reset loads byte offset 0x00 with 0xC40, 0x04 with 0x1384, 0x08 with 0x2BFF8010, 0x0C with 0x255E0091, 0x10 with 0x6140, 0x1C and 0x20 with 0x1FF, 0x68 with 0x8, and 0x6C with 0x10000000. Every other register in the bank resets to zero.
- R2: The bank covers byte offsets 0x00 to 0x6C, with register index = offset / 4. An aligned write to an ordinary register stores the full word, and a read returns it from the next cycle on.
- R3: A write to offset 0x30 stores the word at 0x30 and ORs it into the enable mask at 0x38.
- R4: A write to offset 0x34 stores the word at 0x34 and clears its one bits from the enable mask at 0x38.
- R5: Writes to offsets 0x38 and 0x3C change nothing. The enable mask changes only through writes to 0x30 or 0x34.
- R6: A write to offset 0x04 whose data has bit 2 set, while the stored bit 2 is 0, raises sys_rst_req for exactly the one cycle after the write edge. The written word is stored in any case. Any other write leaves sys_rst_req low.
- R7: Offset 0x3C reads the value status_i had at the previous clock edge.
- R8: Writes to offsets 0x70 and above change nothing, and reads there return zero.
- R9: A write whose address has either of its two low bits set is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one access per cycle |
| addr | input | 8 | Byte address of the access |
| wdata | input | 32 | Write data |
| status_i | input | 32 | External interrupt status vector |
| rdata | output | 32 | Read data for addr, combinational |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
A register that picks up a wrong value shows it on rdata as soon as its offset is read, which is the cycle after the bad write. Each sweep therefore reads back all 64 offsets after every pass of writes. A corrupted enable mask appears at 0x38 after the next set or clear write. A sequencer stuck in FIRE, or one that never fires, shows on sys_rst_req within one cycle of the write to 0x04. The bench samples that output in the cycle after the write and again in the cycle after that.

// File: rtl/hbr_pkg.sv
package hbr_pkg;
    localparam int HBR_DW      = 32;
    localparam int HBR_AW      = 8;
    localparam int HBR_NREGS   = 28;
    localparam int IDX_GENCFG  = 1;
    localparam int IDX_ENSET   = 12;
    localparam int IDX_ENCLR   = 13;
    localparam int IDX_ENMASK  = 14;
    localparam int IDX_STATUS  = 15;
    localparam int RSTREQ_BIT  = 2;

    typedef enum logic [2:0] {
        WK_NONE,
        WK_PLAIN,
        WK_ENSET,
        WK_ENCLR,
        WK_GENCFG,
        WK_RO
    } wr_kind_e;

    function automatic logic [HBR_DW-1:0] hbr_rst_value(input int idx);
        logic [HBR_DW-1:0] v;
        unique case (idx)
            0:       v = 32'h0000_0C40;
            1:       v = 32'h0000_1384;
            2:       v = 32'h2BFF_8010;
            3:       v = 32'h255E_0091;
            4:       v = 32'h0000_6140;
            7, 8:    v = 32'h0000_01FF;
            26:      v = 32'h0000_0008;
            27:      v = 32'h1000_0000;
            default: v = '0;
        endcase
        return v;
    endfunction
endpackage

// File: rtl/hbr_decode.sv
module hbr_decode
    import hbr_pkg::*;
#(
    parameter int AW    = HBR_AW,
    parameter int NREGS = HBR_NREGS,
    localparam int IW   = AW - 2
) (
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    output logic [IW-1:0] idx,
    output logic          in_bank,
    output wr_kind_e      kind
);
    logic aligned;

    assign idx     = addr[AW-1:2];
    assign aligned = (addr[1:0] == 2'b00);
    assign in_bank = (idx < IW'(NREGS));

    always_comb begin
        kind = WK_NONE;
        if (wr_en && aligned && in_bank) begin
            unique case (idx)
                IW'(IDX_ENSET):  kind = WK_ENSET;
                IW'(IDX_ENCLR):  kind = WK_ENCLR;
                IW'(IDX_GENCFG): kind = WK_GENCFG;
                IW'(IDX_ENMASK),
                IW'(IDX_STATUS): kind = WK_RO;
                default:         kind = WK_PLAIN;
            endcase
        end
    end
endmodule

// File: rtl/hbr_rstreq_fsm.sv
module hbr_rstreq_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic trigger,
    output logic pulse
);
    typedef enum logic {RQ_IDLE, RQ_FIRE} rq_state_e;

    rq_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RQ_IDLE: if (trigger) state_d = RQ_FIRE;
            RQ_FIRE: state_d = trigger ? RQ_FIRE : RQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            RQ_IDLE: pulse = 1'b0;
            RQ_FIRE: pulse = 1'b1;
        endcase
    end

    assert_fire_after_trigger_R6: assert property (@(posedge clk) disable iff (!rst_n)
        trigger |=> pulse);
    assert_single_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);
endmodule

// File: rtl/hbr_ctrl_regs.sv
module hbr_ctrl_regs
    import hbr_pkg::*;
#(
    parameter int AW    = HBR_AW,
    parameter int DW    = HBR_DW,
    parameter int NREGS = HBR_NREGS,
    localparam int IW   = AW - 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] status_i,
    output logic [DW-1:0] rdata,
    output logic          sys_rst_req
);
    logic [DW-1:0] regs_q [NREGS];
    logic [IW-1:0] idx;
    logic          in_bank;
    wr_kind_e      kind;
    logic          rq_trigger;
    logic [DW-1:0] en_mask;
    logic [DW-1:0] status_q;

    hbr_decode #(.AW(AW), .NREGS(NREGS)) u_decode (
        .wr_en   (wr_en),
        .addr    (addr),
        .idx     (idx),
        .in_bank (in_bank),
        .kind    (kind)
    );

    assign rq_trigger = (kind == WK_GENCFG) && !regs_q[IDX_GENCFG][RSTREQ_BIT]
                        && wdata[RSTREQ_BIT];

    hbr_rstreq_fsm u_rstreq (
        .clk     (clk),
        .rst_n   (rst_n),
        .trigger (rq_trigger),
        .pulse   (sys_rst_req)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) regs_q[i] <= DW'(hbr_rst_value(i));
        end else begin
            regs_q[IDX_STATUS] <= status_i;
            unique case (kind)
                WK_ENSET: begin
                    regs_q[IDX_ENSET]  <= wdata;
                    regs_q[IDX_ENMASK] <= regs_q[IDX_ENMASK] | wdata;
                end
                WK_ENCLR: begin
                    regs_q[IDX_ENCLR]  <= wdata;
                    regs_q[IDX_ENMASK] <= regs_q[IDX_ENMASK] & ~wdata;
                end
                WK_PLAIN, WK_GENCFG: begin
                    for (int i = 0; i < NREGS; i++)
                        if (IW'(i) == idx) regs_q[i] <= wdata;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        if (in_bank)
            for (int i = 0; i < NREGS; i++)
                if (IW'(i) == idx) rdata = regs_q[i];
    end

    assign en_mask  = regs_q[IDX_ENMASK];
    assign status_q = regs_q[IDX_STATUS];

    assert_enset_or_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == AW'(IDX_ENSET*4)) |=> en_mask == ($past(en_mask) | $past(wdata)));
    assert_enclr_and_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == AW'(IDX_ENCLR*4)) |=> en_mask == ($past(en_mask) & ~$past(wdata)));
    assert_mask_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (addr == AW'(IDX_ENSET*4) || addr == AW'(IDX_ENCLR*4))) |=> $stable(en_mask));
    assert_status_mirror_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> status_q == $past(status_i));
endmodule

// File: tb/hbr_ctrl_regs_tb.sv
module hbr_ctrl_regs_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] status_i = '0;
    logic [31:0] rdata;
    logic        sys_rst_req;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] m [28];

    always #10 clk = ~clk;

    hbr_ctrl_regs u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .status_i(status_i), .rdata(rdata), .sys_rst_req(sys_rst_req)
    );

    task automatic chk(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] rv(input int i);
        case (i)
            0: return 32'hC40;       1: return 32'h1384;
            2: return 32'h2BFF8010;  3: return 32'h255E0091;
            4: return 32'h6140;      7: return 32'h1FF;
            8: return 32'h1FF;       26: return 32'h8;
            27: return 32'h10000000; default: return 32'h0;
        endcase
    endfunction

    task automatic rd_chk(input logic [7:0] a, input string req);
        logic [31:0] e;
        @(negedge clk);
        addr = a;
        #1;
        e = (a[7:2] < 28) ? m[a[7:2]] : 32'h0;
        chk(rdata === e, req, rdata, e);
    endtask

    task automatic sweep_read(input string req);
        for (int k = 0; k < 64; k++) rd_chk(8'(k * 4), req);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        int i;
        logic exp_p;
        i = int'(a[7:2]);
        exp_p = 1'b0;
        if (a[1:0] == 2'b00 && i < 28) begin
            if (i == 1) exp_p = !m[1][2] && d[2];
            if (i == 12) begin m[12] = d; m[14] = m[14] | d; end
            else if (i == 13) begin m[13] = d; m[14] = m[14] & ~d; end
            else if (i != 14 && i != 15) m[i] = d;
        end
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        chk(sys_rst_req === exp_p, "R6 pulse", {31'b0, sys_rst_req}, {31'b0, exp_p});
        @(negedge clk);
        wr_en = 1'b0;
        @(posedge clk); #1;
        chk(sys_rst_req === 1'b0, "R6 single", {31'b0, sys_rst_req}, 32'h0);
    endtask

    initial begin
        for (int i = 0; i < 28; i++) m[i] = rv(i);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset contents, R8: reads beyond bank are zero
        sweep_read("R1 R8 reset");
        // R2 R5 R8: write every offset with two patterns, read all back
        for (int pass = 0; pass < 2; pass++) begin
            for (int k = 0; k < 64; k++) begin
                logic [31:0] p;
                p = 32'h5A3C_0000 ^ (32'(k) * 32'h0001_0203);
                if (pass == 1) p = ~p;
                wr(8'(k * 4), p);
            end
            sweep_read("R2 R3 R4 R5 R8 sweep");
        end
        // R3 R4: explicit mask sequences
        wr(8'h34, 32'hFFFF_FFFF);
        rd_chk(8'h38, "R4 clear all");
        wr(8'h30, 32'h0000_00F0);
        wr(8'h30, 32'h8000_0001);
        rd_chk(8'h38, "R3 set accumulate");
        rd_chk(8'h30, "R3 set stored");
        wr(8'h34, 32'h0000_0030);
        rd_chk(8'h38, "R4 partial clear");
        rd_chk(8'h34, "R4 clear stored");
        wr(8'h38, 32'h1234_5678);
        rd_chk(8'h38, "R5 mask ro");
        // R6: 0->1 on bit 2 fires, 1->1 does not
        wr(8'h04, 32'h0000_1380);
        wr(8'h04, 32'h0000_1384);
        rd_chk(8'h04, "R6 stored");
        wr(8'h04, 32'hFFFF_FFFF);
        wr(8'h04, 32'h0);
        wr(8'h04, 32'h4);
        // R7: status mirror
        for (int s = 0; s < 4; s++) begin
            @(negedge clk);
            status_i = 32'hC001_0000 >> s | 32'(s);
            m[15] = status_i;
            @(posedge clk);
            rd_chk(8'h3C, "R7 status");
        end
        wr(8'h3C, 32'hDEAD_BEEF);
        rd_chk(8'h3C, "R5 status ro");
        // R9: misaligned writes ignored
        for (int b = 1; b < 4; b++) wr(8'(8'h40 + b), 32'hBAD0_0000 | 32'(b));
        wr(8'(8'h04 + 1), 32'h0);
        sweep_read("R9 misaligned");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog act=%h exp=%h", 32'h1, 32'h0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule